// File: doc/BRIEF.md
# LPC I/O Cycle Host Engine

This block is the initiating side of a Low Pin Count bus, limited to I/O read and I/O write cycles. A back-end presents a 16-bit I/O address, a byte of write data and one of two active-high requests. While the engine is idle it takes the request, then sequences the whole cycle on the 4-bit multiplexed LAD lines. The phases are a start clock under an active-low frame strobe, a cycle-type nibble, the address nibbles, the write data nibbles (writes only), a two-clock turnaround, a sync wait, the read data nibbles (reads only) and a two-clock final turnaround.

LAD is presented as three separate on-chip signals: an output nibble, an output enable and an input nibble. The pad tristate stays outside the block. The sync wait holds for as long as the peripheral drives anything other than 0000. It does not tell short waits from long waits and has no timeout. A ready flag and a 4-bit phase code tell the back-end when the next request can be taken. Read data stays on its output until the next read completes.

Top module: `lpc_io_host`

## Requirements
- R1: While rst_n is low at a clock edge, and after it, the block shows ready=1, frame_n=1, lad_oe=0, state_code=0 and rd_data=0x00.
- R2: A request seen while ready is high is taken at that edge. In the next cycle frame_n is low for exactly one clock, with LAD driven to 0000 and ready low.
- R3: The clock after the start clock drives the cycle-type nibble: 0010 for a write and 0000 for a read. When req_wr and req_rd are both high, the write is taken.
- R4: The next four clocks drive the address nibbles, most significant nibble first (bits 15:12 first, bits 3:0 last).
- R5: A write then drives two data nibbles, low nibble (bits 3:0) first. A read skips this phase.
- R6: The first turnaround clock drives 1111. From the second turnaround clock until the engine is idle again, LAD is released (lad_oe=0).
- R7: The sync phase repeats for every clock in which lad_i is not 0000, whatever the nonzero code. It ends at the first clock in which lad_i equals 0000.
- R8: A read samples two data nibbles from lad_i in the two clocks after sync, low nibble first. The byte appears on rd_data when ready returns. A write leaves rd_data unchanged.
- R9: Two final turnaround clocks follow sync (writes) or read data (reads), and ready is high in the clock after them. Requests raised while the engine is busy are ignored.
- R10: state_code encodes the phase: 0 idle, 1 start, 2 cycle type, 3 address, 4 write data, 5 turnaround drive, 6 turnaround release, 7 sync, 8 read data, 9 final turnaround 1, 10 final turnaround 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_addr | input | 16 | I/O address, taken with a request |
| req_wdata | input | 8 | Write data, taken with a request |
| req_rd | input | 1 | Active-high I/O read request |
| req_wr | input | 1 | Active-high I/O write request |
| lad_i | input | 4 | LAD value seen at the pad |
| lad_o | output | 4 | LAD value to drive |
| lad_oe | output | 1 | LAD output enable |
| frame_n | output | 1 | Active-low frame strobe |
| rd_data | output | 8 | Byte returned by the last read |
| ready | output | 1 | High when a new request can be taken |
| state_code | output | 4 | Current phase code |

## Verification
The assertions watch, on every cycle, the invariants that hold at any point of any cycle:
- the start clock drives 0000 for exactly one clock;
- a legal cycle-type nibble follows the start clock;
- the bus is released after the 1111 turnaround;
- nothing is driven while ready is high;
- sync stays put under a nonzero LAD;
- the latched direction and the read byte stay stable outside their own phases.

The bench's transactions are the only evidence of the following:
- nibble order and values for address and data;
- the exact cycle counts with varying sync waits;
- the read byte assembled from the peripheral's nibbles;
- the write winning when both requests are raised;
- requests made mid-cycle having no effect.

// File: rtl/lpc_host_pkg.sv
// Shared phase encoding and LAD codes for the LPC I/O host engine.
// Assumes 4-bit LAD nibbles; the phase values are visible on state_code.
package lpc_host_pkg;

    typedef enum logic [3:0] {
        PH_IDLE   = 4'd0,
        PH_START  = 4'd1,
        PH_CTYPE  = 4'd2,
        PH_ADDR   = 4'd3,
        PH_WDATA  = 4'd4,
        PH_TAR_A  = 4'd5,
        PH_TAR_B  = 4'd6,
        PH_SYNC   = 4'd7,
        PH_RDATA  = 4'd8,
        PH_FTAR_A = 4'd9,
        PH_FTAR_B = 4'd10
    } phase_t;

    localparam logic [3:0] LAD_START_CODE = 4'b0000;
    localparam logic [3:0] LAD_CT_IO_RD   = 4'b0000;
    localparam logic [3:0] LAD_CT_IO_WR   = 4'b0010;
    localparam logic [3:0] LAD_TAR_CODE   = 4'b1111;
    localparam logic [3:0] LAD_SYNC_DONE  = 4'b0000;

endpackage

// File: rtl/lpc_host_seq.sv
// Phase sequencer: walks one I/O read or write cycle phase by phase.
// Assumes ADDR_NIB >= DATA_NIB and that the requests are only looked at in idle.
// Sync waits loop on any nonzero LAD value, with no timeout.
module lpc_host_seq
    import lpc_host_pkg::*;
#(
    parameter int ADDR_NIB = 4,
    parameter int DATA_NIB = 2,
    parameter int CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_rd,
    input  logic             req_wr,
    input  logic [3:0]       lad_i,
    output phase_t           phase,
    output logic [CNT_W-1:0] nib_idx,
    output logic             is_write,
    output logic             accept
);

    phase_t phase_nx;
    logic   addr_last;
    logic   data_last;

    assign accept    = (phase == PH_IDLE) && (req_rd || req_wr);
    assign addr_last = (nib_idx == CNT_W'(ADDR_NIB - 1));
    assign data_last = (nib_idx == CNT_W'(DATA_NIB - 1));

    // Next-phase selection for the I/O cycle sequence.
    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE:   if (accept) phase_nx = PH_START;
            PH_START:  phase_nx = PH_CTYPE;
            PH_CTYPE:  phase_nx = PH_ADDR;
            PH_ADDR:   if (addr_last) phase_nx = is_write ? PH_WDATA : PH_TAR_A;
            PH_WDATA:  if (data_last) phase_nx = PH_TAR_A;
            PH_TAR_A:  phase_nx = PH_TAR_B;
            PH_TAR_B:  phase_nx = PH_SYNC;
            PH_SYNC:   if (lad_i == LAD_SYNC_DONE) phase_nx = is_write ? PH_FTAR_A : PH_RDATA;
            PH_RDATA:  if (data_last) phase_nx = PH_FTAR_A;
            PH_FTAR_A: phase_nx = PH_FTAR_B;
            PH_FTAR_B: phase_nx = PH_IDLE;
            default:   phase_nx = PH_IDLE;
        endcase
    end

    // Phase register and per-phase nibble counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            nib_idx <= '0;
        end else begin
            phase   <= phase_nx;
            nib_idx <= (phase_nx != phase) ? '0 : nib_idx + 1'b1;
        end
    end

    // Cycle direction latched on acceptance; write wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)      is_write <= 1'b0;
        else if (accept) is_write <= req_wr;
    end

    // R7
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SYNC && lad_i != LAD_SYNC_DONE) |=> (phase == PH_SYNC));

    // R9
    busy_dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> $stable(is_write));

endmodule

// File: rtl/lpc_host_drive.sv
// LAD output generator: holds the taken address and data and selects
// the nibble driven in each host-driven phase. The enable is high only
// in the host's own phases.
module lpc_host_drive
    import lpc_host_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_t            phase,
    input  logic              is_write,
    input  logic [CNT_W-1:0]  nib_idx,
    output logic [3:0]        lad_o,
    output logic              lad_oe,
    output logic              frame_n
);

    localparam int ADDR_NIB = ADDR_W / 4;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Hold the address and write data of the cycle in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Nibble and enable selection per phase.
    always_comb begin
        int a_sel;
        int d_sel;
        a_sel   = ADDR_NIB - 1 - int'(nib_idx);
        d_sel   = int'(nib_idx);
        lad_o   = LAD_TAR_CODE;
        lad_oe  = 1'b0;
        frame_n = 1'b1;
        case (phase)
            PH_START: begin
                lad_o   = LAD_START_CODE;
                lad_oe  = 1'b1;
                frame_n = 1'b0;
            end
            PH_CTYPE: begin
                lad_o  = is_write ? LAD_CT_IO_WR : LAD_CT_IO_RD;
                lad_oe = 1'b1;
            end
            PH_ADDR: begin
                lad_o  = addr_q[a_sel*4 +: 4];
                lad_oe = 1'b1;
            end
            PH_WDATA: begin
                lad_o  = wdata_q[d_sel*4 +: 4];
                lad_oe = 1'b1;
            end
            PH_TAR_A: begin
                lad_o  = LAD_TAR_CODE;
                lad_oe = 1'b1;
            end
            default: begin
                lad_o  = LAD_TAR_CODE;
                lad_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lpc_host_capture.sv
// Read data assembler: shifts in LAD nibbles low-first during the read
// data phase and publishes the byte on the last nibble. It holds that
// byte otherwise.
module lpc_host_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              cap_last,
    input  logic [3:0]        lad_i,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] shift_nx;

    assign shift_nx = {lad_i, shift_q[DATA_W-1:4]};

    // Nibble shift register and published byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            rdata   <= '0;
        end else if (cap_en) begin
            shift_q <= shift_nx;
            if (cap_last) rdata <= shift_nx;
        end
    end

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(rdata));

endmodule

// File: rtl/lpc_io_host.sv
// LPC I/O cycle host engine top. Ties the sequencer, the LAD driver and
// the read capture together. Assumes the pad tristate sits outside
// (lad_o / lad_oe / lad_i).
module lpc_io_host
    import lpc_host_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [3:0]        lad_i,
    output logic [3:0]        lad_o,
    output logic              lad_oe,
    output logic              frame_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready,
    output logic [3:0]        state_code
);

    localparam int ADDR_NIB = ADDR_W / 4;
    localparam int DATA_NIB = DATA_W / 4;
    localparam int MAX_NIB  = (ADDR_NIB > DATA_NIB) ? ADDR_NIB : DATA_NIB;
    localparam int CNT_W    = $clog2(MAX_NIB + 1);

    phase_t           phase;
    logic [CNT_W-1:0] nib_idx;
    logic             is_write;
    logic             accept;

    lpc_host_seq #(.ADDR_NIB(ADDR_NIB), .DATA_NIB(DATA_NIB), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .lad_i(lad_i),
        .phase(phase), .nib_idx(nib_idx), .is_write(is_write), .accept(accept)
    );

    lpc_host_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_drive (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
        .req_wdata(req_wdata), .phase(phase), .is_write(is_write), .nib_idx(nib_idx),
        .lad_o(lad_o), .lad_oe(lad_oe), .frame_n(frame_n)
    );

    lpc_host_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_en(phase == PH_RDATA),
        .cap_last(nib_idx == CNT_W'(DATA_NIB - 1)), .lad_i(lad_i), .rdata(rd_data)
    );

    assign ready      = (phase == PH_IDLE);
    assign state_code = phase;

    // R2
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |-> (lad_oe && lad_o == LAD_START_CODE && !ready));

    // R2
    frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> frame_n);

    // R3
    ctype_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> (lad_oe && (lad_o == LAD_CT_IO_RD || lad_o == LAD_CT_IO_WR)));

    // R6
    tar_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'(PH_TAR_A)) |=> !lad_oe);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (frame_n && !lad_oe));

endmodule

// File: tb/lpc_io_host_test.sv
// Self-checking bench: a bench-side peripheral model answers sync and
// read data. Directed cycles plus seeded random ones.
module lpc_io_host_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_rd = 1'b0;
    logic        req_wr = 1'b0;
    logic [3:0]  lad_i = 4'hF;
    logic [3:0]  lad_o;
    logic        lad_oe;
    logic        frame_n;
    logic [7:0]  rd_data;
    logic        ready;
    logic [3:0]  state_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [7:0] last_rd = 8'h00;

    always #10 clk = ~clk;

    lpc_io_host uut (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_rd(req_rd), .req_wr(req_wr), .lad_i(lad_i), .lad_o(lad_o),
        .lad_oe(lad_oe), .frame_n(frame_n), .rd_data(rd_data), .ready(ready),
        .state_code(state_code)
    );

    function automatic logic [3:0] addr_nib(logic [15:0] a, int k);
        return a[(3 - k)*4 +: 4];
    endfunction

    function automatic logic [3:0] data_nib(logic [7:0] d, int k);
        return d[k*4 +: 4];
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // mode: 0 read, 1 write, 2 both requests (write expected)
    task automatic run_cycle(int mode, logic [15:0] a, logic [7:0] d,
                             int waits, logic [3:0] wcode, logic [7:0] pdata, bit noise);
        bit wr;
        wr = (mode != 0);
        req_addr  = a;
        req_wdata = d;
        req_rd    = (mode != 1);
        req_wr    = (mode != 0);
        lad_i     = 4'hF;
        @(negedge clk);
        check("R2 frame", frame_n, 0);
        check("R2 lad start", {lad_oe, lad_o}, 5'h10);
        check("R2 ready low", ready, 0);
        check("R10 start code", state_code, 1);
        req_rd = 1'b0;
        req_wr = 1'b0;
        @(negedge clk);
        check("R3 ctype", {lad_oe, lad_o}, wr ? 5'h12 : 5'h10);
        check("R2 frame one clock", frame_n, 1);
        for (int k = 0; k < 4; k++) begin
            if (noise && k == 1) begin req_rd = 1'b1; req_wr = 1'b1; end
            else begin req_rd = 1'b0; req_wr = 1'b0; end
            @(negedge clk);
            check("R4 addr nibble", {lad_oe, lad_o}, {1'b1, addr_nib(a, k)});
            check("R10 addr code", state_code, 3);
        end
        req_rd = 1'b0;
        req_wr = 1'b0;
        if (wr) begin
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                check("R5 data nibble", {lad_oe, lad_o}, {1'b1, data_nib(d, k)});
            end
        end
        @(negedge clk);
        check("R6 tar drive", {lad_oe, lad_o}, 5'h1F);
        check("R10 tar code", state_code, 5);
        @(negedge clk);
        check("R6 tar release", lad_oe, 0);
        check("R10 tar2 code", state_code, 6);
        for (int i = 0; i <= waits; i++) begin
            @(negedge clk);
            check("R7 sync state", state_code, 7);
            check("R6 sync released", lad_oe, 0);
            lad_i = (i < waits) ? wcode : 4'h0;
        end
        if (!wr) begin
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                check("R8 rdata phase", state_code, 8);
                check("R6 rdata released", lad_oe, 0);
                lad_i = data_nib(pdata, k);
            end
            last_rd = pdata;
        end
        @(negedge clk);
        lad_i = 4'hF;
        check("R9 ftar1", {lad_oe, state_code}, 5'h09);
        @(negedge clk);
        check("R9 ftar2", {lad_oe, state_code}, 5'h0A);
        @(negedge clk);
        check("R9 ready back", {ready, state_code}, 5'h10);
        check("R8 rd_data", rd_data, last_rd);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h1234;
        void'($urandom(seed));
        req_rd = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state, even with a request pending
        check("R1 ready", ready, 1);
        check("R1 frame_n", frame_n, 1);
        check("R1 lad_oe", lad_oe, 0);
        check("R1 state", state_code, 0);
        check("R1 rd_data", rd_data, 0);
        req_rd = 1'b0;
        rst_n  = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {ready, state_code}, 5'h10);

        run_cycle(1, 16'hF0F0, 8'h5A, 0, 4'h5, 8'h00, 1'b0);
        run_cycle(0, 16'hF0F0, 8'h00, 2, 4'h5, 8'hA5, 1'b0);
        run_cycle(2, 16'h1234, 8'hC3, 3, 4'h6, 8'h00, 1'b0);  // R3 both -> write
        run_cycle(1, 16'hABCD, 8'h0F, 1, 4'h6, 8'h00, 1'b1);  // R9 noise ignored
        run_cycle(0, 16'h0001, 8'h00, 0, 4'h5, 8'h3C, 1'b1);  // R7 no wait
        for (int t = 0; t < 40; t++) begin
            int m;
            m = $urandom % 3;
            run_cycle(m, 16'($urandom), 8'($urandom), $urandom % 6,
                      4'(($urandom % 15) + 1), 8'($urandom), 1'($urandom % 2));
        end
        // R9 idle gap: no request means no cycle
        repeat (3) begin
            @(negedge clk);
            check("R9 stays idle", {ready, frame_n, lad_oe}, 3'b110);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule